// File: doc/BRIEF.md
# Pulse-Width Encoded Poll Command Transmitter

This block sends one fixed 24-bit poll command over a single shared data line. A processor write to the block's bus address starts it. The block acknowledges the write on the next clock. It then shifts the command out most significant bit first, adds one stop bit and releases the line. Each logical bit takes four equal slots. The line is low in the first slot and high in the last slot. The two middle slots carry the bit value, so a receiver can sample in the middle of every bit.

Slot timing comes from a clock-enable tick of about 1 µs, divided down from the system clock. The divide ratio is derived from two parameters, the clock frequency and the tick rate. The line is open-drain. The block asserts an output enable only when the line must be pulled low, and it never drives the line high. A one-cycle done pulse marks the end of the stop bit, so that a response receiver can start watching the line.

Top module: `cmd_serial_tx`

## Requirements
- R1: After reset, `line_oe`, `busy`, `done` and `bus_ack` are all 0.
- R2: `bus_ack` is 1 in the cycle after a cycle in which `bus_sel`=1, `bus_wr`=1 and `bus_addr` equals `BASE_ADDR`, and is 0 after every other cycle.
- R3: A write as in R2 accepted while `busy`=0 makes `busy` 1 from the next cycle for exactly 100×DIV cycles, where DIV = CLK_HZ/TICK_HZ.
- R4: Bits leave in the order bit 23 down to bit 0 of the command value 24'h400302. Each bit lasts four slots of DIV cycles each.
- R5: A 0 bit is driven as low, low, low, high. A 1 bit is driven as low, high, high, high. Low means `line_oe`=1 and high means `line_oe`=0.
- R6: A 25th bit of value 1 (the stop bit) follows the 24 command bits.
- R7: `line_oe` is 0 whenever `busy` is 0, including after the stop bit.
- R8: `done` is 1 for exactly one cycle: the cycle right after the last busy cycle.
- R9: A write to the block's address while `busy`=1 is acknowledged but does not restart or lengthen the transfer.
- R10: A read to the block's address, or a write to any other address, starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus transaction start strobe, one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Transaction address |
| bus_ack | output | 1 | Transfer acknowledge, one cycle after the strobe |
| line_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse after the stop bit |

## Verification
The bench builds the expected line waveform, slot by slot, from the command value. It compares that waveform with the design's outputs on every clock, so a flipped bit order shows up at the first differing slot. A swapped slot pattern for 0 or 1 shows up the same way, and so does a slot one cycle too long. A write issued in the middle of a transfer would make a faulty design restart. The bench checks this through the total busy length. A design that failed to arm a new transfer in the same cycle as `done` would be caught by a write issued exactly then. Writes to a wrong address, and reads, are included so that a design that decodes too loosely acknowledges or starts where it must not. The bench also counts the low cycles in a whole transfer: 65×DIV for this command.

// File: rtl/cst_pkg.sv
package cst_pkg;
  localparam int SLOTS_PER_BIT = 4;
  localparam int STOP_BITS     = 1;

  // 1 when the line must be pulled low for this bit value in this slot
  function automatic logic slot_low(input logic bit_val, input logic [1:0] slot);
    case (slot)
      2'd0:    slot_low = 1'b1;
      2'd1,
      2'd2:    slot_low = ~bit_val;
      default: slot_low = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cst_tick_div.sv
module cst_tick_div #(
  parameter int DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cst_bus_if.sv
module cst_bus_if #(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              busy,
  output logic              bus_ack,
  output logic              start
);
  logic hit_wr;
  logic ack_d;

  always_comb begin
    hit_wr = bus_sel && bus_wr && (bus_addr == BASE_ADDR);
    ack_d  = hit_wr;
    start  = hit_wr && !busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_ack <= 1'b0;
    else        bus_ack <= ack_d;
  end
endmodule

// File: rtl/cst_bit_seq.sv
module cst_bit_seq
  import cst_pkg::*;
#(
  parameter int               CMD_W = 24,
  parameter logic [CMD_W-1:0] CMD   = 24'h400302
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic done,
  output logic line_oe
);
  localparam int NBITS = CMD_W + STOP_BITS;
  localparam int IW    = $clog2(NBITS + 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NBITS - 1);

  logic [IW-1:0] idx_q, idx_d;
  logic [1:0]    slot_q, slot_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          cur_bit;

  // value of the bit now on the line: command MSB first, then stop bit(s) of 1
  always_comb begin
    cur_bit = 1'b1;
    for (int i = 0; i < CMD_W; i++) begin
      if (idx_q == IW'(i)) cur_bit = CMD[CMD_W-1-i];
    end
  end

  always_comb begin
    idx_d  = idx_q;
    slot_d = slot_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        idx_d  = '0;
        slot_d = 2'd0;
      end
    end else if (tick) begin
      if (slot_q == 2'(SLOTS_PER_BIT - 1)) begin
        slot_d = 2'd0;
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          done_d = 1'b1;
          idx_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end else begin
        slot_d = slot_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      slot_q <= 2'd0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      slot_q <= slot_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign line_oe = busy_q && slot_low(cur_bit, slot_q);
endmodule

// File: rtl/cmd_serial_tx.sv
module cmd_serial_tx #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h0290_0000,
  parameter int                CLK_HZ    = 25_000_000,
  parameter int                TICK_HZ   = 1_000_000,
  parameter int                CMD_W     = 24,
  parameter logic [CMD_W-1:0]  CMD       = 24'h400302
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              bus_ack,
  output logic              line_oe,
  output logic              busy,
  output logic              done
);
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  logic start;
  logic tick;

  cst_bus_if #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .busy(busy), .bus_ack(bus_ack), .start(start)
  );

  cst_tick_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  cst_bit_seq #(.CMD_W(CMD_W), .CMD(CMD)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .busy(busy), .done(done), .line_oe(line_oe)
  );
endmodule

// File: rtl/cmd_serial_tx_chk.sv
module cmd_serial_tx_chk #(
  parameter int                ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_ack,
  input logic              line_oe,
  input logic              busy,
  input logic              done
);
  logic hit;
  assign hit = bus_sel && bus_wr && (bus_addr == BASE_ADDR);

  AST_ACK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> bus_ack); // R2
  AST_NO_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> !bus_ack); // R10
  AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !busy) |=> busy); // R3
  AST_NO_STRAY_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !busy) |=> !busy); // R10
  AST_LINE_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !line_oe); // R7
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_BUSY_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> line_oe); // R5
endmodule

bind cmd_serial_tx cmd_serial_tx_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_ack(bus_ack), .line_oe(line_oe),
  .busy(busy), .done(done)
);

// File: tb/cmd_serial_tx_tb.sv
module cmd_serial_tx_tb;
  localparam int          ADDR_W = 32;
  localparam logic [31:0] BASE   = 32'h0290_0000;
  localparam int          DIV    = 4;
  localparam logic [23:0] CMDV   = 24'h400302;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0;
  logic bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic bus_ack, line_oe, busy, done;

  int errors = 0;
  int checks = 0;
  int q[$];
  logic exp_ack = 1'b0;
  logic exp_done = 1'b0;
  int busy_run = 0;
  int low_run = 0;
  int last_busy_len = 0;
  int last_low_len = 0;

  always #5 clk = ~clk;

  cmd_serial_tx #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CLK_HZ(4_000_000),
                  .TICK_HZ(1_000_000), .CMD_W(24), .CMD(CMDV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .line_oe(line_oe),
    .busy(busy), .done(done)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0b expected=%0b", what, $time, act, exp);
    end
  endtask

  task automatic chk_int(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // expected line levels for one transfer, built from the requirements
  task automatic load_transfer();
    for (int b = 0; b < 25; b++) begin
      logic v;
      v = (b < 24) ? CMDV[23-b] : 1'b1;   // R4 MSB first, R6 stop bit = 1
      for (int s = 0; s < 4; s++) begin
        int lo;
        lo = (s == 0) ? 1 : (s == 3) ? 0 : (v ? 0 : 1); // R5
        for (int c = 0; c < DIV; c++) q.push_back(lo);
      end
    end
  endtask

  // compare at negedge, then advance the model for the next rising edge
  always @(negedge clk) begin
    logic hit;
    int sz;
    if (rst_n) begin
      chk(line_oe, (q.size() > 0) ? logic'(q[0]) : 1'b0, "R5 R7 line_oe");
      chk(busy, q.size() > 0, "R3 busy");
      chk(bus_ack, exp_ack, "R2 bus_ack");
      chk(done, exp_done, "R8 done");
      if (busy) begin
        busy_run++;
        if (line_oe) low_run++;
      end else if (busy_run != 0) begin
        last_busy_len = busy_run;
        last_low_len  = low_run;
        busy_run = 0;
        low_run  = 0;
      end
      hit = bus_sel && bus_wr && (bus_addr == BASE);
      sz  = q.size();
      exp_ack  = hit;
      exp_done = (sz == 1);
      if (sz > 0) void'(q.pop_front());
      if (hit && sz == 0) load_transfer();  // R9: ignored while busy
    end
  end

  task automatic access(input logic [31:0] a, input logic w);
    @(posedge clk); #1;
    bus_sel = 1'b1; bus_wr = w; bus_addr = a;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
  endtask

  task automatic wait_idle();
    while (busy !== 1'b1 && q.size() > 0) @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(line_oe, 1'b0, "R1 reset line_oe");
    chk(busy, 1'b0, "R1 reset busy");
    chk(bus_ack, 1'b0, "R1 reset ack");
    chk(done, 1'b0, "R1 reset done");
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: wrong address write and a read do nothing
    access(BASE + 32'h4, 1'b1);
    access(BASE, 1'b0);
    repeat (4) @(negedge clk);
    chk(busy, 1'b0, "R10 no start from read or other address");
    chk(line_oe, 1'b0, "R10 R7 line released");

    // R3/R4/R5/R6: a full transfer, with a write in the middle (R9)
    access(BASE, 1'b1);
    repeat (150) @(posedge clk);
    access(BASE, 1'b1);
    wait_idle();
    chk_int(last_busy_len, 100 * DIV, "R3 R9 busy length");
    chk_int(last_low_len, 65 * DIV, "R5 R6 low cycle count");
    chk(line_oe, 1'b0, "R7 line high after stop");

    // R8: new write issued in the done cycle is accepted
    access(BASE, 1'b1);
    @(posedge done); #1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = BASE;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    @(negedge clk);
    chk(busy, 1'b1, "R8 R3 restart right after done");
    wait_idle();
    chk_int(last_busy_len, 100 * DIV, "R3 second busy length");

    repeat (5) @(posedge clk);
    finish_run();
  end
endmodule